// File: doc/BRIEF.md
# Two-Channel Prioritized DMA Engine

This block moves data between memory and peripheral registers over a single 32-bit bus master port. It has two channels. Each channel holds a source address, a destination address, an element count, separate source and destination element widths, separate burst codes, separate address-increment controls and a flow type. Software programs a channel through a small word-addressed register port. A channel then runs one burst each time it is requested, either by its peripheral request line or by a software request bit. Read data passes through a four-word FIFO that belongs to that channel before it is written out.

Channel 0 always wins over channel 1. The engine looks at the two requests only when no burst is running, so a burst that has started always runs to its end. When its count reaches zero, a channel raises a transfer-end status. An illegal flow setting or an error response on the bus raises an error status instead and disables the channel. Both status sets are write-1-to-clear, and they drive the interrupt outputs directly.

Register words (`reg_addr`): channel n uses words 4n to 4n+3. These are the source address, the destination address, control and configuration. Word 8 is the software request register, word 9 is transfer-end status and word 10 is error status. Bus data is right-aligned, with the least significant byte in bits 7:0.

Top module: `dma2_top`

## Requirements
- R1: When both channels have a pending request at a burst boundary, channel 0 is served first.
- R2: Arbitration happens only between bursts. A channel 1 burst that is in progress finishes all its reads and writes before a channel 0 request is served.
- R3: Control bit 22 (source) and bit 23 (destination) select whether an address advances by the element size after each element or stays fixed. The element size is 1, 2 or 4 bytes for width codes 0, 1 and 2. Addresses never wrap.
- R4: Control bits 19:18 hold the source width code and bits 21:20 hold the destination width code. Read data is kept right-aligned and masked to the source width. Write data is masked to the destination width. `m_size` carries the width code of the current beat.
- R5: Burst code c (source at control bits 14:12, destination at bits 17:15) means 1 element for c=0 and 2<<c elements otherwise. The smaller of the two codes is used. One request moves that many elements, or the remaining count if it is smaller, and ends with a one-cycle `burst_ack` pulse for that channel.
- R6: If the 12-bit count (control bits 11:0) is zero, setting the enable bit (configuration bit 0) sets transfer-end status at once and produces no bus activity.
- R7: Flow code 3 (configuration bits 2:1, peripheral to peripheral) is rejected. The enable bit sets error status, the channel stays disabled and no bus activity occurs.
- R8: Writing 1 to bit n of register word 8 requests one burst of channel n, if that channel is enabled. With flow code 0 (memory to memory), the `dreq` line of that channel is ignored.
- R9: With flow code 1 or 2, a high `dreq` bit requests bursts for that channel.
- R10: An error response (`m_err` with `m_ready`) aborts the channel. Its error status is set, its enable is cleared, no further beats are issued, and only successfully read elements are taken from the count.
- R11: When the count reaches zero, transfer-end status is set and enable is cleared. Writing 1 to a bit of word 9 or word 10 clears that status bit. `irq_tc` and `irq_err` show the status bits.
- R12: `m_valid` stays high, and the address, direction and write data stay stable, until `m_ready` is seen.
- R13: Writes to any register word of a channel are ignored while that channel is enabled.
- R14: The FIFO holds four elements. A burst longer than four elements alternates four reads with four writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the word in `reg_addr` |
| dreq | input | 2 | Peripheral request, one bit per channel |
| burst_ack | output | 2 | One-cycle pulse at the end of each burst |
| m_valid | output | 1 | Bus beat request |
| m_write | output | 1 | 1 = write beat, 0 = read beat |
| m_addr | output | 32 | Byte address of the beat |
| m_size | output | 2 | Width code of the beat |
| m_wdata | output | 32 | Write data, right-aligned |
| m_ready | input | 1 | Beat accepted and completed this cycle |
| m_rdata | input | 32 | Read data, valid with `m_ready` |
| m_err | input | 1 | Error response, valid with `m_ready` |
| irq_tc | output | 2 | Transfer-end interrupt per channel |
| irq_err | output | 2 | Error interrupt per channel |

## Verification
Most internal faults show up on the bus within one burst. A wrong FIFO level or a miscounted remaining length changes the pattern of reads and writes, or the number of beats. A wrong address step shows on `m_addr` at the second element. A wrong arbitration decision shows as the wrong channel's address range at the first beat after a boundary. Count and enable faults show up at the end of the transfer, as a missing or early `irq_tc` or as a remaining count in the control word that differs from the expected value.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

  localparam int NCH    = 2;
  localparam int CH_W   = $clog2(NCH);
  localparam int DATA_W = 32;
  localparam int CNT_W  = 12;

  typedef enum logic [1:0] {
    FLOW_M2M = 2'd0,
    FLOW_M2P = 2'd1,
    FLOW_P2M = 2'd2,
    FLOW_P2P = 2'd3
  } flow_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } eng_st_e;

  typedef struct packed {
    logic             dinc;
    logic             sinc;
    logic [1:0]       dwid;
    logic [1:0]       swid;
    logic [2:0]       dbst;
    logic [2:0]       sbst;
    logic [CNT_W-1:0] cnt;
  } ctrl_t;

  function automatic logic [2:0] step_bytes(input logic [1:0] w);
    case (w)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] width_mask(input logic [DATA_W-1:0] d,
                                                   input logic [1:0] w);
    case (w)
      2'd0:    return {{(DATA_W-8){1'b0}}, d[7:0]};
      2'd1:    return {{(DATA_W-16){1'b0}}, d[15:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [8:0] burst_len(input logic [2:0] code);
    return (code == 3'd0) ? 9'd1 : (9'd2 << code);
  endfunction

endpackage

// File: rtl/dma2_fifo.sv
module dma2_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + PW'(1);
      if (pop)  rp_q <= rp_q + PW'(1);
      lvl_q <= lvl_q + LW'(push) - LW'(pop);
    end
  end

  assign dout  = mem[rp_q];
  assign level = lvl_q;
endmodule

// File: rtl/dma2_arb.sv
module dma2_arb #(
  parameter int N = 2
) (
  input  logic [N-1:0]         req,
  output logic                 any,
  output logic [$clog2(N)-1:0] id
);
  localparam int IW = $clog2(N);

  always_comb begin
    any = |req;
    id  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) id = IW'(i);
    end
  end
endmodule

// File: rtl/dma2_top.sv
module dma2_top
  import dma2_pkg::*;
#(
  parameter int AW         = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NCH-1:0]    dreq,
  output logic [NCH-1:0]    burst_ack,
  output logic              m_valid,
  output logic              m_write,
  output logic [AW-1:0]     m_addr,
  output logic [1:0]        m_size,
  output logic [DATA_W-1:0] m_wdata,
  input  logic              m_ready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic              m_err,
  output logic [NCH-1:0]    irq_tc,
  output logic [NCH-1:0]    irq_err
);
  localparam int LW = $clog2(FIFO_DEPTH+1);

  eng_st_e          st_q;
  logic [CH_W-1:0]  act_q;
  logic [CNT_W-1:0] left_q;

  logic [AW-1:0] src_q [NCH];
  logic [AW-1:0] dst_q [NCH];
  ctrl_t         ctl_q [NCH];
  flow_e         flow_q [NCH];
  logic [NCH-1:0] en_q, swreq_q, tc_q, er_q, ack_q;

  logic [NCH-1:0]    req;
  logic              gnt_v;
  logic [CH_W-1:0]   gnt_id;
  logic [NCH-1:0]    f_push, f_pop, f_clr;
  logic [DATA_W-1:0] f_head [NCH];
  logic [LW-1:0]     f_lvl  [NCH];

  ctrl_t             act_ctl, gnt_ctl;
  logic [2:0]        gnt_code;
  logic [CNT_W-1:0]  gnt_len, gnt_left;
  logic              beat_ok, beat_err, last_rd;
  logic [DATA_W-1:0] act_head;
  logic [LW-1:0]     act_lvl;

  // Request and grant
  for (genvar i = 0; i < NCH; i++) begin : g_req
    assign req[i] = en_q[i] & (swreq_q[i] | (dreq[i] & (flow_q[i] != FLOW_M2M)));
  end

  dma2_arb #(.N(NCH)) u_arb (
    .req (req),
    .any (gnt_v),
    .id  (gnt_id)
  );

  assign gnt_ctl  = ctl_q[gnt_id];
  assign gnt_code = (gnt_ctl.sbst < gnt_ctl.dbst) ? gnt_ctl.sbst : gnt_ctl.dbst;
  assign gnt_len  = CNT_W'(burst_len(gnt_code));
  assign gnt_left = (gnt_len < gnt_ctl.cnt) ? gnt_len : gnt_ctl.cnt;

  // Per-channel FIFOs
  assign beat_ok  = m_valid & m_ready & ~m_err;
  assign beat_err = m_valid & m_ready & m_err;

  for (genvar i = 0; i < NCH; i++) begin : g_fifo
    assign f_push[i] = beat_ok  & (st_q == ST_READ)  & (act_q == CH_W'(i));
    assign f_pop[i]  = beat_ok  & (st_q == ST_WRITE) & (act_q == CH_W'(i));
    assign f_clr[i]  = beat_err & (act_q == CH_W'(i));

    dma2_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .clr   (f_clr[i]),
      .push  (f_push[i]),
      .din   (width_mask(m_rdata, ctl_q[i].swid)),
      .pop   (f_pop[i]),
      .dout  (f_head[i]),
      .level (f_lvl[i])
    );
  end

  assign act_ctl  = ctl_q[act_q];
  assign act_head = f_head[act_q];
  assign act_lvl  = f_lvl[act_q];
  assign last_rd  = (left_q == CNT_W'(1)) || (act_lvl == LW'(FIFO_DEPTH - 1));

  // Bus master outputs
  assign m_valid = (st_q != ST_IDLE);
  assign m_write = (st_q == ST_WRITE);
  assign m_addr  = m_write ? dst_q[act_q] : src_q[act_q];
  assign m_size  = m_write ? act_ctl.dwid : act_ctl.swid;
  assign m_wdata = width_mask(act_head, act_ctl.dwid);

  // Registers and engine
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      act_q   <= '0;
      left_q  <= '0;
      en_q    <= '0;
      swreq_q <= '0;
      tc_q    <= '0;
      er_q    <= '0;
      ack_q   <= '0;
      for (int i = 0; i < NCH; i++) begin
        src_q[i]  <= '0;
        dst_q[i]  <= '0;
        ctl_q[i]  <= '0;
        flow_q[i] <= FLOW_M2M;
      end
    end else begin
      ack_q <= '0;

      if (reg_we) begin
        if (!reg_addr[3]) begin
          if (!en_q[reg_addr[2]]) begin
            case (reg_addr[1:0])
              2'd0: src_q[reg_addr[2]] <= reg_wdata[AW-1:0];
              2'd1: dst_q[reg_addr[2]] <= reg_wdata[AW-1:0];
              2'd2: ctl_q[reg_addr[2]] <= ctrl_t'(reg_wdata[$bits(ctrl_t)-1:0]);
              default: begin
                flow_q[reg_addr[2]] <= flow_e'(reg_wdata[2:1]);
                if (reg_wdata[0]) begin
                  if (flow_e'(reg_wdata[2:1]) == FLOW_P2P)
                    er_q[reg_addr[2]] <= 1'b1;
                  else if (ctl_q[reg_addr[2]].cnt == '0)
                    tc_q[reg_addr[2]] <= 1'b1;
                  else
                    en_q[reg_addr[2]] <= 1'b1;
                end
              end
            endcase
          end
        end else begin
          case (reg_addr[2:0])
            3'd0: swreq_q <= swreq_q | (reg_wdata[NCH-1:0] & en_q);
            3'd1: tc_q    <= tc_q & ~reg_wdata[NCH-1:0];
            3'd2: er_q    <= er_q & ~reg_wdata[NCH-1:0];
            default: ;
          endcase
        end
      end

      unique case (st_q)
        ST_IDLE: begin
          if (gnt_v) begin
            act_q           <= gnt_id;
            left_q          <= gnt_left;
            swreq_q[gnt_id] <= 1'b0;
            st_q            <= ST_READ;
          end
        end
        ST_READ: begin
          if (beat_err) begin
            er_q[act_q]    <= 1'b1;
            en_q[act_q]    <= 1'b0;
            swreq_q[act_q] <= 1'b0;
            st_q           <= ST_IDLE;
          end else if (beat_ok) begin
            if (act_ctl.sinc) src_q[act_q] <= src_q[act_q] + AW'(step_bytes(act_ctl.swid));
            ctl_q[act_q].cnt <= act_ctl.cnt - CNT_W'(1);
            left_q <= left_q - CNT_W'(1);
            if (last_rd) st_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (beat_err) begin
            er_q[act_q]    <= 1'b1;
            en_q[act_q]    <= 1'b0;
            swreq_q[act_q] <= 1'b0;
            st_q           <= ST_IDLE;
          end else if (beat_ok) begin
            if (act_ctl.dinc) dst_q[act_q] <= dst_q[act_q] + AW'(step_bytes(act_ctl.dwid));
            if (act_lvl == LW'(1)) begin
              if (left_q == '0) begin
                st_q         <= ST_IDLE;
                ack_q[act_q] <= 1'b1;
                if (act_ctl.cnt == '0) begin
                  tc_q[act_q] <= 1'b1;
                  en_q[act_q] <= 1'b0;
                end
              end else begin
                st_q <= ST_READ;
              end
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (!reg_addr[3]) begin
      case (reg_addr[1:0])
        2'd0:    reg_rdata <= 32'(src_q[reg_addr[2]]);
        2'd1:    reg_rdata <= 32'(dst_q[reg_addr[2]]);
        2'd2:    reg_rdata <= 32'(ctl_q[reg_addr[2]]);
        default: reg_rdata <= {29'd0, flow_q[reg_addr[2]], en_q[reg_addr[2]]};
      endcase
    end else begin
      case (reg_addr[2:0])
        3'd0:    reg_rdata <= 32'(swreq_q);
        3'd1:    reg_rdata <= 32'(tc_q);
        3'd2:    reg_rdata <= 32'(er_q);
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign burst_ack = ack_q;
  assign irq_tc    = tc_q;
  assign irq_err   = er_q;
endmodule

// File: rtl/dma2_chk.sv
module dma2_chk
  import dma2_pkg::*;
#(
  parameter int AW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              m_valid,
  input logic              m_write,
  input logic [AW-1:0]     m_addr,
  input logic [DATA_W-1:0] m_wdata,
  input logic              m_ready,
  input logic              m_err,
  input logic [NCH-1:0]    en,
  input logic [NCH-1:0]    burst_ack,
  input logic [NCH-1:0]    irq_tc,
  input logic [NCH-1:0]    irq_err
);
  // R12
  p_hold_beat_r12: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_wdata)));

  // R5
  p_single_ack_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(burst_ack));

  // R10
  p_err_raises_irq_r10: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_ready && m_err) |=> (irq_err != '0));

  // R10
  p_err_stops_bus_r10: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_ready && m_err) |=> !m_valid);

  // R8
  p_bus_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (en != '0));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R11
    p_tc_disables_r11: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_tc[i]) |-> !en[i]);
  end
endmodule

bind dma2_top dma2_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .m_valid   (m_valid),
  .m_write   (m_write),
  .m_addr    (m_addr),
  .m_wdata   (m_wdata),
  .m_ready   (m_ready),
  .m_err     (m_err),
  .en        (en_q),
  .burst_ack (burst_ack),
  .irq_tc    (irq_tc),
  .irq_err   (irq_err)
);

// File: tb/tb_dma2_top.sv
`timescale 1ns/1ps
module tb_dma2_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  dreq = '0;
  logic [1:0]  burst_ack;
  logic        m_valid, m_write;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [1:0]  m_size;
  logic        m_ready = 1'b1;
  logic        m_err = 1'b0;
  logic [1:0]  irq_tc, irq_err;

  int ntests = 0;
  int nfail  = 0;

  dma2_top dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dreq(dreq), .burst_ack(burst_ack), .m_valid(m_valid),
    .m_write(m_write), .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata),
    .m_ready(m_ready), .m_rdata(m_rdata), .m_err(m_err), .irq_tc(irq_tc), .irq_err(irq_err)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0]};
  endfunction

  assign m_rdata = pat(m_addr);

  // Bus responder and beat log
  bit          stall_mode = 1'b0;
  int          err_idx = -1;
  int          nrd = 0;
  int          ncyc = 0;
  int          nlog = 0;
  logic        lw [256];
  logic [31:0] la [256];
  logic [31:0] ld [256];
  logic [1:0]  ls [256];

  always @(negedge clk) begin
    logic rdy;
    rdy = stall_mode ? ((ncyc % 3) != 2) : 1'b1;
    ncyc++;
    m_ready = rdy;
    m_err = m_valid && !m_write && rdy && (nrd == err_idx);
    if (m_valid && rdy && nlog < 256) begin
      lw[nlog] = m_write;
      la[nlog] = m_addr;
      ld[nlog] = m_wdata;
      ls[nlog] = m_size;
      nlog++;
      if (!m_write) nrd++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [31:0] mkctl(input int cnt, input int sb, input int db,
                                        input int sw, input int dw, input bit si, input bit di);
    return 32'(cnt) | (32'(sb) << 12) | (32'(db) << 15) | (32'(sw) << 18) |
           (32'(dw) << 20) | (32'(si) << 22) | (32'(di) << 23);
  endfunction

  task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d,
                       input logic [31:0] ctl, input logic [31:0] cfg);
    reg_wr(4'(ch * 4 + 0), s);
    reg_wr(4'(ch * 4 + 1), d);
    reg_wr(4'(ch * 4 + 2), ctl);
    reg_wr(4'(ch * 4 + 3), cfg);
  endtask

  task automatic clear_log();
    @(negedge clk);
    nlog = 0; nrd = 0;
  endtask

  task automatic wait_bit(input int which, input int ch);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (which == 0 && irq_tc[ch]) break;
      if (which == 1 && irq_err[ch]) break;
      if (which == 2 && burst_ack[ch]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_beat(input string req, input int i, input logic w, input logic [31:0] a);
    chk(req, {31'd0, lw[i]}, {31'd0, w});
    chk(req, la[i], a);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("reset irq_tc", 32'(irq_tc), 0);
    chk("reset irq_err", 32'(irq_err), 0);
    chk("reset m_valid", 32'(m_valid), 0);
    reg_rd(4'd2, d);
    chk("reset ctl", d, 0);
  endtask

  task automatic t_m2m_basic();
    logic [31:0] d;
    clear_log();
    setup(0, 32'h1000, 32'h2000, mkctl(6, 1, 2, 2, 2, 1, 1), 32'h1);
    reg_wr(4'd8, 32'h1);
    wait_bit(2, 0);
    chk("R5 first burst beats", 32'(nlog), 8);
    for (int i = 0; i < 4; i++) chk_beat("R14 read then write", i, 1'b0, 32'h1000 + 32'(4 * i));
    for (int i = 0; i < 4; i++) begin
      chk_beat("R3 dst step", 4 + i, 1'b1, 32'h2000 + 32'(4 * i));
      chk("R4 data", ld[4 + i], pat(32'h1000 + 32'(4 * i)));
    end
    reg_rd(4'd2, d);
    chk("R5 remaining count", d & 32'hFFF, 2);
    chk("R11 no tc mid", 32'(irq_tc[0]), 0);
    reg_wr(4'd8, 32'h1);
    wait_bit(0, 0);
    chk("R5 tail beats", 32'(nlog), 12);
    chk_beat("R3 last write", 11, 1'b1, 32'h2014);
    chk("R11 tc", 32'(irq_tc[0]), 1);
    reg_rd(4'd3, d);
    chk("R11 enable cleared", d & 1, 0);
    reg_wr(4'd9, 32'h1);
    @(negedge clk);
    chk("R11 w1c tc", 32'(irq_tc[0]), 0);
  endtask

  task automatic t_width();
    clear_log();
    setup(1, 32'h3003, 32'h4000, mkctl(3, 2, 2, 0, 1, 0, 1), 32'h1);
    reg_wr(4'd8, 32'h2);
    wait_bit(0, 1);
    chk("R3 beats", 32'(nlog), 6);
    for (int i = 0; i < 3; i++) begin
      chk_beat("R3 src held", i, 1'b0, 32'h3003);
      chk("R4 read size", 32'(ls[i]), 0);
      chk_beat("R3 dst step 2", 3 + i, 1'b1, 32'h4000 + 32'(2 * i));
      chk("R4 write size", 32'(ls[3 + i]), 1);
      chk("R4 masked data", ld[3 + i], 32'h03);
    end
    reg_wr(4'd9, 32'h2);
  endtask

  task automatic t_dreq_ignored();
    logic [31:0] d;
    clear_log();
    setup(0, 32'h1100, 32'h2100, mkctl(2, 0, 0, 2, 2, 1, 1), 32'h1);
    dreq = 2'b01;
    repeat (30) @(negedge clk);
    chk("R8 m2m ignores dreq beats", 32'(nlog), 0);
    reg_rd(4'd2, d);
    chk("R8 m2m count kept", d & 32'hFFF, 2);
    dreq = 2'b00;
    reg_wr(4'd8, 32'h1);
    wait_bit(2, 0);
    reg_wr(4'd8, 32'h1);
    wait_bit(0, 0);
    chk("R8 sw start", 32'(nlog), 4);
    reg_wr(4'd9, 32'h1);
  endtask

  task automatic t_hw();
    clear_log();
    setup(1, 32'h5100, 32'h6100, mkctl(5, 1, 1, 2, 2, 0, 1), 32'h5);
    dreq = 2'b10;
    wait_bit(0, 1);
    dreq = 2'b00;
    chk("R9 hw beats", 32'(nlog), 10);
    chk_beat("R9 last write", 9, 1'b1, 32'h6110);
    chk("R9 tc", 32'(irq_tc[1]), 1);
    reg_wr(4'd9, 32'h2);
  endtask

  task automatic t_prio();
    clear_log();
    setup(0, 32'h7000, 32'h7100, mkctl(1, 0, 0, 2, 2, 1, 1), 32'h1);
    setup(1, 32'h7200, 32'h7300, mkctl(1, 0, 0, 2, 2, 1, 1), 32'h1);
    reg_wr(4'd8, 32'h3);
    wait_bit(0, 1);
    wait_bit(0, 0);
    chk("R1 beats", 32'(nlog), 4);
    chk_beat("R1 ch0 first", 0, 1'b0, 32'h7000);
    chk_beat("R1 ch1 after", 2, 1'b0, 32'h7200);
    reg_wr(4'd9, 32'h3);
  endtask

  task automatic t_nopreempt();
    clear_log();
    setup(1, 32'h5000, 32'h6000, mkctl(8, 2, 2, 2, 2, 1, 1), 32'h1);
    setup(0, 32'h7000, 32'h7800, mkctl(1, 0, 0, 2, 2, 1, 1), 32'h1);
    reg_wr(4'd8, 32'h2);
    for (int i = 0; i < 200 && nlog < 1; i++) @(negedge clk);
    reg_wr(4'd8, 32'h1);
    wait_bit(0, 1);
    wait_bit(0, 0);
    chk("R2 beats", 32'(nlog), 18);
    for (int i = 0; i < 4; i++) begin
      chk_beat("R14 ch1 reads a", i, 1'b0, 32'h5000 + 32'(4 * i));
      chk_beat("R14 ch1 writes a", 4 + i, 1'b1, 32'h6000 + 32'(4 * i));
      chk_beat("R2 ch1 reads b", 8 + i, 1'b0, 32'h5010 + 32'(4 * i));
      chk_beat("R2 ch1 writes b", 12 + i, 1'b1, 32'h6010 + 32'(4 * i));
    end
    chk_beat("R2 ch0 after burst", 16, 1'b0, 32'h7000);
    reg_wr(4'd9, 32'h3);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    clear_log();
    setup(0, 32'h1000, 32'h2000, mkctl(0, 0, 0, 2, 2, 1, 1), 32'h1);
    chk("R6 immediate tc", 32'(irq_tc[0]), 1);
    repeat (10) @(negedge clk);
    chk("R6 no beats", 32'(nlog), 0);
    reg_rd(4'd3, d);
    chk("R6 enable low", d & 1, 0);
    reg_wr(4'd9, 32'h1);
  endtask

  task automatic t_p2p();
    logic [31:0] d;
    clear_log();
    setup(1, 32'h1000, 32'h2000, mkctl(4, 0, 0, 2, 2, 1, 1), 32'h7);
    chk("R7 error set", 32'(irq_err[1]), 1);
    dreq = 2'b10;
    repeat (10) @(negedge clk);
    dreq = 2'b00;
    chk("R7 no beats", 32'(nlog), 0);
    reg_rd(4'd7, d);
    chk("R7 enable low", d & 1, 0);
    reg_wr(4'd10, 32'h2);
    @(negedge clk);
    chk("R11 w1c err", 32'(irq_err[1]), 0);
  endtask

  task automatic t_buserr();
    logic [31:0] d;
    clear_log();
    err_idx = 2;
    setup(0, 32'h8000, 32'h9000, mkctl(4, 1, 1, 2, 2, 1, 1), 32'h1);
    reg_wr(4'd8, 32'h1);
    wait_bit(1, 0);
    repeat (20) @(negedge clk);
    err_idx = -1;
    chk("R10 err irq", 32'(irq_err[0]), 1);
    chk("R10 beats stop", 32'(nlog), 3);
    reg_rd(4'd3, d);
    chk("R10 enable cleared", d & 1, 0);
    reg_rd(4'd2, d);
    chk("R10 count", d & 32'hFFF, 2);
    reg_wr(4'd10, 32'h1);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    clear_log();
    setup(0, 32'hA000, 32'hB000, mkctl(1, 0, 0, 2, 2, 1, 1), 32'h1);
    reg_wr(4'd0, 32'hDEAD0000);
    reg_rd(4'd0, d);
    chk("R13 src locked", d, 32'hA000);
    reg_wr(4'd8, 32'h1);
    wait_bit(0, 0);
    chk_beat("R13 old src used", 0, 1'b0, 32'hA000);
    reg_wr(4'd9, 32'h1);
  endtask

  task automatic t_stall();
    clear_log();
    stall_mode = 1'b1;
    setup(1, 32'hC000, 32'hD000, mkctl(4, 1, 1, 2, 2, 1, 1), 32'h1);
    reg_wr(4'd8, 32'h2);
    wait_bit(0, 1);
    stall_mode = 1'b0;
    chk("R12 beats under stall", 32'(nlog), 8);
    for (int i = 0; i < 4; i++) begin
      chk_beat("R12 read", i, 1'b0, 32'hC000 + 32'(4 * i));
      chk("R12 data", ld[4 + i], pat(32'hC000 + 32'(4 * i)));
    end
    reg_wr(4'd9, 32'h2);
  endtask

  initial begin
    #(4 * 150000);
    ntests++;
    nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_m2m_basic();
    t_width();
    t_dreq_ignored();
    t_hw();
    t_prio();
    t_nopreempt();
    t_zero();
    t_p2p();
    t_buserr();
    t_lock();
    t_stall();
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule